// File: doc/BRIEF.md
# Slice Fast-Carry Logic

This block is the fast-carry section of one logic slice. It holds two carry multiplexers in series, a lower stage and an upper stage, and one sum XOR gate per stage. The lookup tables sit outside the block. Their two outputs, a few of their address pins and two bypass inputs feed the block, together with static configuration selects. Those selects choose where the chain starts and where each stage takes its propagate and generate terms.

The carry start is either the incoming chain carry or a bypass pin. The propagate term of a stage is either its lookup output or a forced 1, which skips that stage. The generate term of a stage is one of these: a constant, one of two address pins, a bypass pin, or the AND of the two address pins (used for multiplier partial products). A stage with propagate 1 passes its generate term. Otherwise it passes the carry that arrives from below. Two bypass outputs can each carry either a chain carry or a shift-register tap that comes from outside the block.

Slices are chained by connecting `cout` of one slice to `cin` of the next. The path is purely combinational, with no storage.

Top module: `slice_carry_logic`

## Requirements
- R1: When `cfg_init_bx` is 0 the chain start is `cin`; when it is 1 the chain start is `bx`, and `cin` has no effect on any output.
- R2: The lower stage propagate is `f_lut` when `cfg_lo_prop_one` is 0 and constant 1 when it is 1. `carry_mid` equals the lower generate value when that propagate is 1, otherwise the chain start.
- R3: The lower generate is chosen by `cfg_lo_gen`: 0 gives 0, 1 gives 1, 2 gives `f_addr[0]`, 3 gives `f_addr[1]`, 4 gives `bx`, and 5 gives `f_addr[0] & f_addr[1]`.
- R4: The upper generate is chosen by `cfg_hi_gen` with the same codes, using `g_addr[0]`, `g_addr[1]` and `by`.
- R5: The upper stage propagate is `g_lut` when `cfg_hi_prop_one` is 0 and 1 when it is 1. `cout` equals the upper generate value when that propagate is 1, otherwise `carry_mid`.
- R6: `sum_lo` equals `f_lut` XOR the chain start.
- R7: `sum_hi` equals `g_lut` XOR `carry_mid`.
- R8: `xb` equals `carry_mid` when `cfg_xb_tap` is 0 and `f_tap` when it is 1.
- R9: `yb` equals `cout` when `cfg_yb_tap` is 0 and `g_tap` when it is 1.
- R10: The unused generate codes 6 and 7 give a generate value of 0 in both stages.
- R11: Eight slices chained `cout` to `cin` compare two 16-bit operands A and B. Each slice is set up with lookups A^B, generate code 2 fed by A, and the first slice starting from `bx`. The last `cout` is then (A > B) or (A == B and carry-in), and sum bit k is (A^B)[k] XOR the comparison result of bits below k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cin | input | 1 | Carry arriving from the slice below |
| bx | input | 1 | Lower bypass pin |
| by | input | 1 | Upper bypass pin |
| f_lut | input | 1 | Lower lookup output |
| g_lut | input | 1 | Upper lookup output |
| f_addr | input | 2 | Lower lookup address pins 1 and 2 (bit 0 is pin 1) |
| g_addr | input | 2 | Upper lookup address pins 1 and 2 (bit 0 is pin 1) |
| f_tap | input | 1 | Lower lookup shift tap |
| g_tap | input | 1 | Upper lookup shift tap |
| cfg_init_bx | input | 1 | Chain start select: 0 from cin, 1 from bx |
| cfg_lo_prop_one | input | 1 | Force lower propagate to 1 |
| cfg_hi_prop_one | input | 1 | Force upper propagate to 1 |
| cfg_lo_gen | input | 3 | Lower generate source code |
| cfg_hi_gen | input | 3 | Upper generate source code |
| cfg_xb_tap | input | 1 | xb shows the shift tap instead of the carry |
| cfg_yb_tap | input | 1 | yb shows the shift tap instead of the carry |
| carry_mid | output | 1 | Carry out of the lower stage |
| cout | output | 1 | Carry out of the slice |
| sum_lo | output | 1 | Lower sum |
| sum_hi | output | 1 | Upper sum |
| xb | output | 1 | Lower bypass output |
| yb | output | 1 | Upper bypass output |

## Verification
A single slice is driven with random values on every input and configuration select, including the reserved generate codes. This shows the two propagate sources against each other and tells the six generate sources apart. Directed cases cover three situations: the forced-propagate skip, a chain start taken from `bx` while `cin` toggles, and each bypass selection with a carry and tap of opposite value. A chain of eight slices is set up as a magnitude comparator and fed equal operands, extreme operands, operands that differ only in the top bit, and random operands, with both carry-in values. This tells a correct ripple direction and a correct stage ordering from swapped or broken links.

// File: rtl/slice_carry_pkg.sv
package slice_carry_pkg;
  localparam int GEN_SEL_W  = 3;
  localparam int ADDR_PINS  = 2;
  localparam int NUM_STAGES = 2;

  localparam logic [GEN_SEL_W-1:0] GEN_ZERO   = 3'd0;
  localparam logic [GEN_SEL_W-1:0] GEN_ONE    = 3'd1;
  localparam logic [GEN_SEL_W-1:0] GEN_PIN_A  = 3'd2;
  localparam logic [GEN_SEL_W-1:0] GEN_PIN_B  = 3'd3;
  localparam logic [GEN_SEL_W-1:0] GEN_BYPASS = 3'd4;
  localparam logic [GEN_SEL_W-1:0] GEN_PROD   = 3'd5;
endpackage

// File: rtl/scl_chain_start.sv
module scl_chain_start (
  input  logic use_bypass,
  input  logic chain_in,
  input  logic bypass_in,
  output logic start
);
  always_comb begin
    if (use_bypass) start = bypass_in;
    else            start = chain_in;
  end
endmodule

// File: rtl/scl_gen_select.sv
module scl_gen_select
  import slice_carry_pkg::*;
#(
  parameter int SEL_W = GEN_SEL_W,
  parameter int PINS  = ADDR_PINS
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [PINS-1:0]  pins,
  input  logic             bypass_in,
  output logic             gen
);
  always_comb begin
    case (sel)
      GEN_ZERO:   gen = 1'b0;
      GEN_ONE:    gen = 1'b1;
      GEN_PIN_A:  gen = pins[0];
      GEN_PIN_B:  gen = pins[1];
      GEN_BYPASS: gen = bypass_in;
      GEN_PROD:   gen = pins[0] & pins[1];
      default:    gen = 1'b0;
    endcase
  end
endmodule

// File: rtl/scl_carry_stage.sv
module scl_carry_stage (
  input  logic carry_in,
  input  logic lut_out,
  input  logic prop_one,
  input  logic gen,
  output logic carry_out,
  output logic sum
);
  logic prop;

  always_comb begin
    prop = prop_one | lut_out;
    if (prop) carry_out = gen;
    else      carry_out = carry_in;
    sum = lut_out ^ carry_in;
  end
endmodule

// File: rtl/scl_bypass_mux.sv
module scl_bypass_mux (
  input  logic carry,
  input  logic tap,
  input  logic pick_tap,
  output logic out
);
  always_comb begin
    if (pick_tap) out = tap;
    else          out = carry;
  end
endmodule

// File: rtl/slice_carry_logic.sv
module slice_carry_logic
  import slice_carry_pkg::*;
(
  input  logic                 cin,
  input  logic                 bx,
  input  logic                 by,
  input  logic                 f_lut,
  input  logic                 g_lut,
  input  logic [ADDR_PINS-1:0] f_addr,
  input  logic [ADDR_PINS-1:0] g_addr,
  input  logic                 f_tap,
  input  logic                 g_tap,
  input  logic                 cfg_init_bx,
  input  logic                 cfg_lo_prop_one,
  input  logic                 cfg_hi_prop_one,
  input  logic [GEN_SEL_W-1:0] cfg_lo_gen,
  input  logic [GEN_SEL_W-1:0] cfg_hi_gen,
  input  logic                 cfg_xb_tap,
  input  logic                 cfg_yb_tap,
  output logic                 carry_mid,
  output logic                 cout,
  output logic                 sum_lo,
  output logic                 sum_hi,
  output logic                 xb,
  output logic                 yb
);
  // Stage 0 is the lower half of the slice, stage 1 the upper half.
  logic [NUM_STAGES:0]                  chain;
  logic [NUM_STAGES-1:0]                lut_v;
  logic [NUM_STAGES-1:0]                byp_v;
  logic [NUM_STAGES-1:0]                prop1_v;
  logic [NUM_STAGES-1:0]                tapsel_v;
  logic [NUM_STAGES-1:0]                tap_v;
  logic [NUM_STAGES-1:0]                gen_v;
  logic [NUM_STAGES-1:0]                sum_v;
  logic [NUM_STAGES-1:0]                bout_v;
  logic [NUM_STAGES-1:0][ADDR_PINS-1:0] addr_v;
  logic [NUM_STAGES-1:0][GEN_SEL_W-1:0] gsel_v;

  assign lut_v    = {g_lut, f_lut};
  assign byp_v    = {by, bx};
  assign prop1_v  = {cfg_hi_prop_one, cfg_lo_prop_one};
  assign tapsel_v = {cfg_yb_tap, cfg_xb_tap};
  assign tap_v    = {g_tap, f_tap};
  assign addr_v   = {g_addr, f_addr};
  assign gsel_v   = {cfg_hi_gen, cfg_lo_gen};

  scl_chain_start u_start (
    .use_bypass (cfg_init_bx),
    .chain_in   (cin),
    .bypass_in  (bx),
    .start      (chain[0])
  );

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    scl_gen_select #(
      .SEL_W (GEN_SEL_W),
      .PINS  (ADDR_PINS)
    ) u_gen (
      .sel       (gsel_v[s]),
      .pins      (addr_v[s]),
      .bypass_in (byp_v[s]),
      .gen       (gen_v[s])
    );

    scl_carry_stage u_stage (
      .carry_in  (chain[s]),
      .lut_out   (lut_v[s]),
      .prop_one  (prop1_v[s]),
      .gen       (gen_v[s]),
      .carry_out (chain[s+1]),
      .sum       (sum_v[s])
    );

    scl_bypass_mux u_byp (
      .carry    (chain[s+1]),
      .tap      (tap_v[s]),
      .pick_tap (tapsel_v[s]),
      .out      (bout_v[s])
    );
  end

  assign carry_mid = chain[1];
  assign cout      = chain[2];
  assign sum_lo    = sum_v[0];
  assign sum_hi    = sum_v[1];
  assign xb        = bout_v[0];
  assign yb        = bout_v[1];
endmodule

// File: rtl/scl_checker.sv
module scl_checker
  import slice_carry_pkg::*;
(
  input logic                 cin,
  input logic                 bx,
  input logic                 by,
  input logic                 f_lut,
  input logic                 g_lut,
  input logic [ADDR_PINS-1:0] f_addr,
  input logic [ADDR_PINS-1:0] g_addr,
  input logic                 f_tap,
  input logic                 g_tap,
  input logic                 cfg_init_bx,
  input logic                 cfg_lo_prop_one,
  input logic                 cfg_hi_prop_one,
  input logic [GEN_SEL_W-1:0] cfg_lo_gen,
  input logic [GEN_SEL_W-1:0] cfg_hi_gen,
  input logic                 cfg_xb_tap,
  input logic                 cfg_yb_tap,
  input logic                 carry_mid,
  input logic                 cout,
  input logic                 sum_lo,
  input logic                 sum_hi,
  input logic                 xb,
  input logic                 yb
);
  logic start_v;
  assign start_v = cfg_init_bx ? bx : cin;

  always_comb begin
    AST_SUM_LO_START: assert (sum_lo == (f_lut ^ start_v)); // R6
    if (!cfg_lo_prop_one && !f_lut)
      AST_LO_PASS_START: assert (carry_mid == start_v); // R2
    if (!cfg_hi_prop_one && !g_lut)
      AST_HI_PASS_MID: assert (cout == carry_mid); // R5
    AST_SUM_HI_MID: assert (sum_hi == (g_lut ^ carry_mid)); // R7
    AST_XB_SELECT: assert (xb == (cfg_xb_tap ? f_tap : carry_mid)); // R8
    AST_YB_SELECT: assert (yb == (cfg_yb_tap ? g_tap : cout)); // R9
    if (cfg_lo_prop_one && (cfg_lo_gen == GEN_ONE))
      AST_LO_GEN_ONE: assert (carry_mid); // R3
    if (cfg_hi_prop_one && (cfg_hi_gen >= 3'd6))
      AST_HI_GEN_RSVD: assert (!cout); // R10
    if (cfg_hi_prop_one && (cfg_hi_gen == GEN_PROD))
      AST_HI_GEN_PROD: assert (cout == (g_addr[0] & g_addr[1])); // R4
    if (cfg_init_bx && !cfg_lo_prop_one && !f_lut)
      AST_START_BX: assert (carry_mid == bx); // R1
  end
endmodule

bind slice_carry_logic scl_checker u_chk (.*);

// File: tb/slice_carry_logic_tb.sv
module slice_carry_logic_tb;
  import slice_carry_pkg::*;

  localparam int NSL = 8;
  localparam int OPW = 2 * NSL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;

  logic       cin, bx, by, f_lut, g_lut, f_tap, g_tap;
  logic [1:0] f_addr, g_addr;
  logic       cfg_init_bx, cfg_lo_prop_one, cfg_hi_prop_one, cfg_xb_tap, cfg_yb_tap;
  logic [2:0] cfg_lo_gen, cfg_hi_gen;
  logic       carry_mid, cout, sum_lo, sum_hi, xb, yb;

  slice_carry_logic u_dut (
    .cin(cin), .bx(bx), .by(by), .f_lut(f_lut), .g_lut(g_lut),
    .f_addr(f_addr), .g_addr(g_addr), .f_tap(f_tap), .g_tap(g_tap),
    .cfg_init_bx(cfg_init_bx), .cfg_lo_prop_one(cfg_lo_prop_one),
    .cfg_hi_prop_one(cfg_hi_prop_one), .cfg_lo_gen(cfg_lo_gen),
    .cfg_hi_gen(cfg_hi_gen), .cfg_xb_tap(cfg_xb_tap), .cfg_yb_tap(cfg_yb_tap),
    .carry_mid(carry_mid), .cout(cout), .sum_lo(sum_lo), .sum_hi(sum_hi),
    .xb(xb), .yb(yb)
  );

  // Comparator chain for R11
  logic [OPW-1:0] op_a, op_b;
  logic           ch_cin;
  logic [OPW-1:0] ch_sum;
  logic [NSL-1:0] ch_co;
  logic [NSL-1:0] ch_mid;
  logic [NSL-1:0] ch_xb, ch_yb;

  for (genvar i = 0; i < NSL; i++) begin : g_chain
    logic link;
    if (i == 0) begin : g_first
      assign link = 1'b0;
    end else begin : g_rest
      assign link = ch_co[i-1];
    end
    slice_carry_logic u_sl (
      .cin(link), .bx((i == 0) ? ch_cin : 1'b0), .by(1'b0),
      .f_lut(op_a[2*i] ^ op_b[2*i]), .g_lut(op_a[2*i+1] ^ op_b[2*i+1]),
      .f_addr({1'b0, op_a[2*i]}), .g_addr({1'b0, op_a[2*i+1]}),
      .f_tap(1'b0), .g_tap(1'b0),
      .cfg_init_bx((i == 0) ? 1'b1 : 1'b0), .cfg_lo_prop_one(1'b0),
      .cfg_hi_prop_one(1'b0), .cfg_lo_gen(3'd2), .cfg_hi_gen(3'd2),
      .cfg_xb_tap(1'b0), .cfg_yb_tap(1'b0),
      .carry_mid(ch_mid[i]), .cout(ch_co[i]), .sum_lo(ch_sum[2*i]),
      .sum_hi(ch_sum[2*i+1]), .xb(ch_xb[i]), .yb(ch_yb[i])
    );
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Generate-source codes from R3/R4/R10
  function automatic logic gen_ref(input logic [2:0] code, input logic [1:0] pins,
                                   input logic byp);
    case (code)
      3'd0: return 1'b0;
      3'd1: return 1'b1;
      3'd2: return pins[0];
      3'd3: return pins[1];
      3'd4: return byp;
      3'd5: return pins[0] & pins[1];
      default: return 1'b0;
    endcase
  endfunction

  task automatic check_single();
    logic st, gl, gh, em, ec;
    st = cfg_init_bx ? bx : cin;                                     // R1
    gl = gen_ref(cfg_lo_gen, f_addr, bx);
    gh = gen_ref(cfg_hi_gen, g_addr, by);
    em = (cfg_lo_prop_one || f_lut) ? gl : st;                       // R2
    ec = (cfg_hi_prop_one || g_lut) ? gh : em;                       // R5
    check("R2", "carry_mid", 32'(carry_mid), 32'(em));
    check("R5", "cout", 32'(cout), 32'(ec));
    check("R6", "sum_lo", 32'(sum_lo), 32'(f_lut ^ st));
    check("R7", "sum_hi", 32'(sum_hi), 32'(g_lut ^ em));
    check("R8", "xb", 32'(xb), 32'(cfg_xb_tap ? f_tap : em));
    check("R9", "yb", 32'(yb), 32'(cfg_yb_tap ? g_tap : ec));
  endtask

  task automatic drive_all(input logic [31:0] r);
    {cin, bx, by, f_lut, g_lut, f_tap, g_tap} = r[6:0];
    f_addr = r[8:7];
    g_addr = r[10:9];
    {cfg_init_bx, cfg_lo_prop_one, cfg_hi_prop_one, cfg_xb_tap, cfg_yb_tap} = r[15:11];
    cfg_lo_gen = r[18:16];
    cfg_hi_gen = r[21:19];
  endtask

  task automatic apply(input logic [31:0] r);
    @(negedge clk);
    drive_all(r);
    #1;
    check_single();
  endtask

  // Arithmetic model of the comparator chain (R11)
  task automatic check_chain(input logic [OPW-1:0] a, input logic [OPW-1:0] b,
                             input logic ci);
    logic [OPW-1:0] es;
    logic           ecout;
    @(negedge clk);
    op_a = a; op_b = b; ch_cin = ci;
    #1;
    for (int k = 0; k < OPW; k++) begin
      logic [OPW-1:0] m;
      logic below;
      m = (OPW'(1) << k) - OPW'(1);
      below = ((a & m) > (b & m)) || (((a & m) == (b & m)) && ci);
      es[k] = a[k] ^ b[k] ^ below;
    end
    ecout = (a > b) || ((a == b) && ci);
    check("R11", "chain cout", 32'(ch_co[NSL-1]), 32'(ecout));
    check("R11", "chain sums", 32'(ch_sum), 32'(es));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    drive_all(32'h0);
    op_a = '0; op_b = '0; ch_cin = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // Reset state: all-zero stimulus gives all-zero outputs
    check("R6", "reset zero outputs", 32'({carry_mid, cout, sum_lo, sum_hi, xb, yb}), 32'h0);
    rst_n = 1'b1;

    // R1: start from bx, cin toggled must not matter
    @(negedge clk);
    drive_all(32'h0);
    cfg_init_bx = 1'b1; bx = 1'b1; cin = 1'b0; #1;
    check("R1", "start bx=1 cin=0", 32'({carry_mid, sum_lo}), 32'b11);
    cin = 1'b1; bx = 1'b0; #1;
    check("R1", "start bx=0 cin=1", 32'({carry_mid, sum_lo}), 32'b00);

    // R2/R5: forced propagate passes generate, f_lut low
    @(negedge clk);
    drive_all(32'h0);
    cin = 1'b1; cfg_lo_prop_one = 1'b1; cfg_lo_gen = 3'd0; #1;
    check("R2", "forced prop passes gen 0", 32'(carry_mid), 32'h0);
    cfg_hi_prop_one = 1'b1; cfg_hi_gen = 3'd1; #1;
    check("R5", "forced upper prop passes gen 1", 32'(cout), 32'h1);

    // R3/R4: every generate code with propagate forced
    for (int c = 0; c < 8; c++) begin
      for (int p = 0; p < 4; p++) begin
        @(negedge clk);
        drive_all(32'h0);
        cfg_lo_prop_one = 1'b1; cfg_hi_prop_one = 1'b1;
        cfg_lo_gen = 3'(c); cfg_hi_gen = 3'(c);
        f_addr = 2'(p); g_addr = 2'(p); bx = p[0]; by = p[1];
        #1;
        check((c >= 6) ? "R10" : "R3", "lower gen code", 32'(carry_mid),
              32'(gen_ref(3'(c), 2'(p), p[0])));
        check((c >= 6) ? "R10" : "R4", "upper gen code", 32'(cout),
              32'(gen_ref(3'(c), 2'(p), p[1])));
      end
    end

    // R8/R9: taps opposite to carries
    @(negedge clk);
    drive_all(32'h0);
    f_tap = 1'b1; g_tap = 1'b1; cfg_xb_tap = 1'b1; cfg_yb_tap = 1'b1; #1;
    check("R8", "xb shows tap", 32'(xb), 32'h1);
    check("R9", "yb shows tap", 32'(yb), 32'h1);
    cfg_xb_tap = 1'b0; cfg_yb_tap = 1'b0; #1;
    check("R8", "xb shows carry", 32'(xb), 32'h0);
    check("R9", "yb shows carry", 32'(yb), 32'h0);

    // Random single-slice stimulus
    for (int n = 0; n < 600; n++) apply($urandom);

    // R11: comparator chain, directed then random
    for (int ci = 0; ci < 2; ci++) begin
      check_chain(16'h1234, 16'h1234, 1'(ci));
      check_chain(16'hffff, 16'h0000, 1'(ci));
      check_chain(16'h0000, 16'hffff, 1'(ci));
      check_chain(16'h8000, 16'h7fff, 1'(ci));
      check_chain(16'h7fff, 16'h8000, 1'(ci));
      check_chain(16'h0001, 16'h0000, 1'(ci));
    end
    for (int n = 0; n < 300; n++)
      check_chain(OPW'($urandom), OPW'($urandom), 1'($urandom));

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule